// File: doc/BRIEF.md
# Double-Stage Serial Transmitter with Sticky Status Flags

This block sends bytes on an asynchronous serial line using 8N1 frames. A CPU writes a byte into a one-entry holding buffer. The buffer passes its byte to a frame shifter as soon as the shifter is free. Because of this, the next byte can already be waiting while the current frame is still on the wire. When it is, consecutive frames go out with no idle time between them.

Software talks to the block through four write strobes:

- **Control register:** transmitter enable and two interrupt enables.
- **Status port:** write-one-to-clear.
- **Baud register:** 16 bits, holding the bit period in quarter-cycle units, so that non-integer periods are possible.
- **Data port:** the byte to send.

The block drives the serial line and the pin output enable. It also drives two interrupt requests:

- **Buffer empty:** level-based, following the state of the holding buffer.
- **Transmission complete:** sticky. It stays asserted until software clears its flag or drops its enable. Servicing the request never clears the flag.

Top module: `uart_tx_buffered`

## Requirements
- R1: After reset, the control register is zero, so the transmitter is disabled and `tx_oe` is low. `dre_flag` is 1, `txc_flag` is 0, both interrupt requests are 0, `tx` is high, and the baud register holds 64.
- R2: The line rests at 1 when no frame is in progress. A frame is one 0 start bit, then the 8 data bits least significant bit first, then one 1 stop bit. The start bit appears in the cycle after the buffer hands its byte to the shifter.
- R3: A phase accumulator adds 4 every cycle and is compared against the baud register value B. Bit boundaries therefore fall every B/4 cycles on average, with no accumulated drift. The accumulator restarts at every frame start. The frame ends at the first cycle count n, counted from the start bit, for which 4·n ≥ 10·B.
- R4: `dre_flag` is 1 exactly when the holding buffer is empty. A data write is taken only when the buffer is empty and the transmitter is enabled; a data write into a full buffer is dropped. Writing 1 to status bit 1 (the buffer-empty position) has no effect.
- R5: A byte written while a frame is being sent goes out directly after that frame's stop bit, with no idle cycle on the line.
- R6: `txc_flag` sets only when a stop bit finishes and the buffer holds no byte. Between back-to-back frames it stays 0.
- R7: Writing a 1 to status bit 0 clears `txc_flag`. A 0 in that bit leaves it unchanged. A completion in the same cycle as the clear wins.
- R8: Control bit 1 enables the buffer-empty request and control bit 2 enables the completion request. Each request equals its flag AND its enable bit. The completion request stays asserted through any number of cycles until the flag is cleared or the enable is dropped.
- R9: Control bit 0 enables the transmitter, and `tx_oe` follows it. While the enable is 0:
  - a frame in progress is abandoned and the holding buffer is emptied;
  - data writes are ignored;
  - `txc_flag` is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| data_wr | input | 1 | Write strobe for the data byte |
| data_in | input | 8 | Byte to transmit |
| ctrl_wr | input | 1 | Write strobe for the control register |
| ctrl_in | input | 3 | Control value: bit0 enable, bit1 buffer-empty request enable, bit2 completion request enable |
| stat_wr | input | 1 | Write strobe for the status port |
| stat_in | input | 2 | Write-one-to-clear mask: bit0 completion flag, bit1 buffer-empty position (ignored) |
| baud_wr | input | 1 | Write strobe for the baud register |
| baud_in | input | 16 | Bit period times four, in clock cycles |
| tx | output | 1 | Serial line |
| tx_oe | output | 1 | Pin output enable |
| dre_flag | output | 1 | Buffer-empty status flag |
| txc_flag | output | 1 | Transmission-complete status flag |
| dre_irq | output | 1 | Buffer-empty interrupt request |
| txc_irq | output | 1 | Transmission-complete interrupt request |

## Verification
A holding buffer that loses track of its contents shows up in one of two ways. It either drops or duplicates a frame on `tx`, or it moves `dre_flag` at the wrong time. Either one is visible within one or two cycles of the handover.

A bad phase accumulator does not show up at once. It shows up as a bit edge that drifts by one cycle somewhere inside the frame. For this reason the line is compared against the reference model on every cycle, and whole-frame durations are measured for fractional baud values.

A completion flag that sets between chained frames, or that clears without a write, is exposed the first time a second byte is queued mid-frame or the request is left pending.

// File: rtl/utx_pkg.sv
package utx_pkg;

    localparam int DATA_W     = 8;
    localparam int FRAME_BITS = DATA_W + 2;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);
    localparam int ACC_STEP   = 4;

    localparam int CTRL_W        = 3;
    localparam int STAT_W        = 2;
    localparam int STAT_TXC_BIT  = 0;
    localparam int STAT_DRE_BIT  = 1;

    // Only the completion flag is clearable; the buffer-empty bit is state-derived.
    localparam logic [STAT_W-1:0] W1C_MASK = STAT_W'(1 << STAT_TXC_BIT);

    typedef struct packed {
        logic txc_ie;
        logic dre_ie;
        logic en;
    } ctrl_t;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } hold_t;

    typedef enum logic {
        SH_IDLE = 1'b0,
        SH_SEND = 1'b1
    } sh_state_e;

    function automatic logic [FRAME_BITS-1:0] build_frame(input logic [DATA_W-1:0] d);
        return {1'b1, d, 1'b0};
    endfunction

    function automatic ctrl_t decode_ctrl(input logic [CTRL_W-1:0] v);
        return ctrl_t'(v);
    endfunction

endpackage

// File: rtl/utx_tick.sv
module utx_tick
    import utx_pkg::*;
#(
    parameter int BAUD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              restart,
    input  logic [BAUD_W-1:0] baud,
    output logic              tick
);
    localparam int ACC_W = BAUD_W + 1;

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_inc;
    logic [ACC_W-1:0] baud_ext;

    assign baud_ext = {1'b0, baud};
    assign acc_inc  = acc_q + ACC_W'(ACC_STEP);
    assign tick     = run && (acc_inc >= baud_ext);

    always_ff @(posedge clk) begin
        if (rst || !run || restart) begin
            acc_q <= '0;
        end else if (tick) begin
            acc_q <= acc_inc - baud_ext;
        end else begin
            acc_q <= acc_inc;
        end
    end
endmodule

// File: rtl/utx_shifter.sv
module utx_shifter
    import utx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              tick,
    output logic              busy,
    output logic              line,
    output logic              frame_end
);
    sh_state_e              state_q;
    logic [FRAME_BITS-1:0]  shreg_q;
    logic [CNT_W-1:0]       cnt_q;

    assign busy      = (state_q == SH_SEND);
    assign frame_end = busy && enable && tick && (cnt_q == CNT_W'(FRAME_BITS - 1));
    assign line      = busy ? shreg_q[0] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            state_q <= SH_IDLE;
            shreg_q <= '1;
            cnt_q   <= '0;
        end else if (load) begin
            state_q <= SH_SEND;
            shreg_q <= build_frame(load_data);
            cnt_q   <= '0;
        end else if (frame_end) begin
            state_q <= SH_IDLE;
            shreg_q <= '1;
            cnt_q   <= '0;
        end else if (busy && tick) begin
            shreg_q <= {1'b1, shreg_q[FRAME_BITS-1:1]};
            cnt_q   <= cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/utx_regs.sv
module utx_regs
    import utx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_in,
    input  logic              stat_wr,
    input  logic [STAT_W-1:0] stat_in,
    input  logic              txc_set,
    input  logic              buf_empty,
    output ctrl_t             ctrl,
    output logic              dre_flag,
    output logic              txc_flag,
    output logic              dre_irq,
    output logic              txc_irq
);
    logic [STAT_W-1:0] clr_bits;
    logic              txc_q;

    assign clr_bits = stat_wr ? (stat_in & W1C_MASK) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (ctrl_wr) begin
            ctrl <= decode_ctrl(ctrl_in);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            txc_q <= 1'b0;
        end else if (txc_set) begin
            txc_q <= 1'b1;
        end else if (clr_bits[STAT_TXC_BIT]) begin
            txc_q <= 1'b0;
        end
    end

    assign dre_flag = buf_empty;
    assign txc_flag = txc_q;
    assign dre_irq  = buf_empty & ctrl.dre_ie;
    assign txc_irq  = txc_q & ctrl.txc_ie;
endmodule

// File: rtl/uart_tx_buffered.sv
module uart_tx_buffered
    import utx_pkg::*;
#(
    parameter int          BAUD_W     = 16,
    parameter logic [15:0] BAUD_RESET = 16'd64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              data_wr,
    input  logic [7:0]        data_in,
    input  logic              ctrl_wr,
    input  logic [2:0]        ctrl_in,
    input  logic              stat_wr,
    input  logic [1:0]        stat_in,
    input  logic              baud_wr,
    input  logic [BAUD_W-1:0] baud_in,
    output logic              tx,
    output logic              tx_oe,
    output logic              dre_flag,
    output logic              txc_flag,
    output logic              dre_irq,
    output logic              txc_irq
);
    ctrl_t             ctrl;
    hold_t             hold_q;
    logic [BAUD_W-1:0] baud_q;
    logic              busy;
    logic              tick;
    logic              frame_end;
    logic              accept;
    logic              load;

    assign accept = data_wr && !hold_q.valid && ctrl.en;
    assign load   = ctrl.en && hold_q.valid && (!busy || frame_end);

    always_ff @(posedge clk) begin
        if (rst || !ctrl.en) begin
            hold_q <= '0;
        end else if (accept) begin
            hold_q.valid <= 1'b1;
            hold_q.data  <= data_in;
        end else if (load) begin
            hold_q.valid <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            baud_q <= BAUD_W'(BAUD_RESET);
        end else if (baud_wr) begin
            baud_q <= baud_in;
        end
    end

    utx_tick #(.BAUD_W(BAUD_W)) u_tick (
        .clk     (clk),
        .rst     (rst),
        .run     (busy),
        .restart (load),
        .baud    (baud_q),
        .tick    (tick)
    );

    utx_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .enable    (ctrl.en),
        .load      (load),
        .load_data (hold_q.data),
        .tick      (tick),
        .busy      (busy),
        .line      (tx),
        .frame_end (frame_end)
    );

    utx_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .ctrl_wr   (ctrl_wr),
        .ctrl_in   (ctrl_in),
        .stat_wr   (stat_wr),
        .stat_in   (stat_in),
        .txc_set   (frame_end && !load),
        .buf_empty (!hold_q.valid),
        .ctrl      (ctrl),
        .dre_flag  (dre_flag),
        .txc_flag  (txc_flag),
        .dre_irq   (dre_irq),
        .txc_irq   (txc_irq)
    );

    assign tx_oe = ctrl.en;
endmodule

// File: rtl/utx_checker.sv
module utx_checker (
    input logic       clk,
    input logic       rst,
    input logic       data_wr,
    input logic       ctrl_wr,
    input logic       stat_wr,
    input logic [1:0] stat_in,
    input logic       tx,
    input logic       tx_oe,
    input logic       dre_flag,
    input logic       txc_flag,
    input logic       txc_irq
);
    a_r4_write_fills_buffer: assert property (@(posedge clk) disable iff (rst)
        data_wr && dre_flag && tx_oe |=> !dre_flag);

    a_r6_complete_on_idle_line: assert property (@(posedge clk) disable iff (rst)
        $rose(txc_flag) |-> tx);

    a_r7_clear_when_quiet: assert property (@(posedge clk) disable iff (rst)
        stat_wr && stat_in[0] && !tx_oe |=> !txc_flag);

    a_r8_request_sticky: assert property (@(posedge clk) disable iff (rst)
        txc_irq && !(stat_wr && stat_in[0]) && !ctrl_wr |=> txc_irq);

    a_r9_disable_flushes: assert property (@(posedge clk) disable iff (rst)
        !tx_oe |=> dre_flag);
endmodule

bind uart_tx_buffered utx_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .data_wr  (data_wr),
    .ctrl_wr  (ctrl_wr),
    .stat_wr  (stat_wr),
    .stat_in  (stat_in),
    .tx       (tx),
    .tx_oe    (tx_oe),
    .dre_flag (dre_flag),
    .txc_flag (txc_flag),
    .txc_irq  (txc_irq)
);

// File: tb/uart_tx_buffered_bench.sv
module uart_tx_buffered_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        data_wr = 1'b0;
    logic [7:0]  data_in = '0;
    logic        ctrl_wr = 1'b0;
    logic [2:0]  ctrl_in = '0;
    logic        stat_wr = 1'b0;
    logic [1:0]  stat_in = '0;
    logic        baud_wr = 1'b0;
    logic [15:0] baud_in = '0;
    logic        tx, tx_oe, dre_flag, txc_flag, dre_irq, txc_irq;

    always #2 clk = ~clk;

    uart_tx_buffered u_uart_tx_buffered (
        .clk(clk), .rst(rst), .data_wr(data_wr), .data_in(data_in),
        .ctrl_wr(ctrl_wr), .ctrl_in(ctrl_in), .stat_wr(stat_wr), .stat_in(stat_in),
        .baud_wr(baud_wr), .baud_in(baud_in), .tx(tx), .tx_oe(tx_oe),
        .dre_flag(dre_flag), .txc_flag(txc_flag), .dre_irq(dre_irq), .txc_irq(txc_irq)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    // Behavioural reference model
    bit       m_en, m_dreie, m_txcie, m_txc, m_bufv, m_busy;
    logic [7:0] m_bufd;
    int       m_acc, m_baud;
    bit       line_q[$];

    always @(posedge clk) begin : model
        bit old_en, old_bufv, fin, ld, wr_ok;
        cyc++;
        if (rst) begin
            m_en = 0; m_dreie = 0; m_txcie = 0; m_txc = 0; m_bufv = 0; m_busy = 0;
            m_bufd = '0; m_acc = 0; m_baud = 64; line_q.delete();
        end else begin
            old_en = m_en; old_bufv = m_bufv; fin = 0; ld = 0;
            wr_ok = data_wr && !old_bufv && old_en;
            if (!old_en) begin
                m_busy = 0; m_bufv = 0; m_acc = 0; line_q.delete();
            end else begin
                if (m_busy) begin
                    if (m_acc + 4 >= m_baud) begin
                        void'(line_q.pop_front());
                        m_acc = m_acc + 4 - m_baud;
                        if (line_q.size() == 0) begin
                            fin = 1; m_busy = 0; m_acc = 0;
                        end
                    end else begin
                        m_acc = m_acc + 4;
                    end
                end
                if (old_bufv && !m_busy) begin
                    ld = 1; m_busy = 1; m_acc = 0; m_bufv = 0;
                    line_q.push_back(1'b0);
                    for (int i = 0; i < 8; i++) line_q.push_back(m_bufd[i]);
                    line_q.push_back(1'b1);
                end
                if (wr_ok) begin
                    m_bufv = 1; m_bufd = data_in;
                end
            end
            if (fin && !ld) m_txc = 1;
            else if (stat_wr && stat_in[0]) m_txc = 0;
            if (ctrl_wr) {m_txcie, m_dreie, m_en} = ctrl_in;
            if (baud_wr) m_baud = int'(baud_in);
        end
    end

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic chk_int(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R2", "line vs model", tx, m_busy ? line_q[0] : 1'b1);
            chk("R9", "tx_oe vs model", tx_oe, m_en);
            chk("R4", "dre_flag vs model", dre_flag, !m_bufv);
            chk("R6", "txc_flag vs model", txc_flag, m_txc);
            chk("R8", "dre_irq vs model", dre_irq, !m_bufv && m_dreie);
            chk("R8", "txc_irq vs model", txc_irq, m_txc && m_txcie);
        end
    end

    task automatic wr_ctrl(input logic [2:0] v);
        @(negedge clk); ctrl_wr = 1; ctrl_in = v;
        @(negedge clk); ctrl_wr = 0;
    endtask
    task automatic wr_data(input logic [7:0] v);
        @(negedge clk); data_wr = 1; data_in = v;
        @(negedge clk); data_wr = 0;
    endtask
    task automatic wr_stat(input logic [1:0] v);
        @(negedge clk); stat_wr = 1; stat_in = v;
        @(negedge clk); stat_wr = 0; stat_in = '0;
    endtask
    task automatic wr_baud(input logic [15:0] v);
        @(negedge clk); baud_wr = 1; baud_in = v;
        @(negedge clk); baud_wr = 0;
    endtask
    task automatic wait_txc(output int n);
        n = 0;
        while (!txc_flag && n < 20000) begin
            @(negedge clk); n++;
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin : stim
        int s, n;
        repeat (5) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1", "tx_oe", tx_oe, 1'b0);
        chk("R1", "dre_flag", dre_flag, 1'b1);
        chk("R1", "txc_flag", txc_flag, 1'b0);
        chk("R1", "irqs", dre_irq | txc_irq, 1'b0);
        chk("R1", "tx idle", tx, 1'b1);

        // R9: writes ignored while disabled
        wr_data(8'h11);
        chk("R9", "write ignored when disabled", dre_flag, 1'b1);

        wr_ctrl(3'b111);
        chk("R8", "dre_irq with empty buffer", dre_irq, 1'b1);

        // Single frame at default period 64 -> 160 cycles
        wr_data(8'hA5);
        s = cyc;
        @(negedge clk);
        chk("R2", "start bit low", tx, 1'b0);
        wait_txc(n);
        chk_int("R3", "frame length at B=64", cyc - s, 161);
        chk("R6", "txc after lone frame", txc_flag, 1'b1);

        // R8 sticky request
        repeat (50) @(negedge clk);
        chk("R8", "txc_irq still pending", txc_irq, 1'b1);
        // R7 zero write no effect; dre-bit write no effect
        wr_stat(2'b10);
        chk("R7", "zero in bit0 keeps flag", txc_flag, 1'b1);
        chk("R4", "dre bit write no effect", dre_flag, 1'b1);
        wr_ctrl(3'b011);
        chk("R8", "request gated by enable", txc_irq, 1'b0);
        chk("R8", "flag kept when enable dropped", txc_flag, 1'b1);
        wr_ctrl(3'b111);
        wr_stat(2'b01);
        chk("R7", "write-one clears", txc_flag, 1'b0);

        // Fractional period 70 -> 175 cycles
        wr_baud(16'd70);
        wr_data(8'h3C);
        s = cyc;
        wait_txc(n);
        chk_int("R3", "frame length at B=70", cyc - s, 176);
        wr_stat(2'b01);

        // Back-to-back frames with a dropped third write
        wr_data(8'h0F);
        s = cyc;
        repeat (20) @(negedge clk);
        chk("R4", "buffer empty after handover", dre_flag, 1'b1);
        wr_data(8'hF0);
        chk("R4", "buffer full after write", dre_flag, 1'b0);
        wr_stat(2'b10);
        chk("R4", "dre bit write leaves buffer full", dre_flag, 1'b0);
        wr_data(8'h55);
        chk("R4", "write into full buffer dropped", dre_flag, 1'b0);
        wait_txc(n);
        chk_int("R5", "two chained frames no gap", cyc - s, 351);
        chk("R6", "single completion for chain", txc_flag, 1'b1);
        repeat (20) @(negedge clk);
        chk("R4", "dropped byte never sent", tx, 1'b1);
        wr_stat(2'b01);

        // R9: disable mid-frame with a byte waiting
        wr_data(8'h00);
        repeat (10) @(negedge clk);
        wr_data(8'hFF);
        repeat (30) @(negedge clk);
        wr_ctrl(3'b110);
        chk("R9", "oe released", tx_oe, 1'b0);
        @(negedge clk);
        chk("R9", "buffer flushed", dre_flag, 1'b1);
        chk("R9", "line high after abort", tx, 1'b1);
        wr_data(8'h77);
        chk("R9", "write ignored while disabled", dre_flag, 1'b1);
        repeat (400) @(negedge clk);
        chk("R9", "no completion after abort", txc_flag, 1'b0);
        wr_ctrl(3'b111);
        chk("R9", "oe back on", tx_oe, 1'b1);
        chk("R2", "idle high after re-enable", tx, 1'b1);

        // Fresh frame after re-enable, odd period 66
        wr_baud(16'd66);
        wr_data(8'h81);
        s = cyc;
        wait_txc(n);
        chk_int("R3", "frame length at B=66", cyc - s, 166);
        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule